// File: doc/BRIEF.md
# DMA Hold-Acknowledge Arbiter

This block decides when the processor hands its bus to a DMA controller. It drives the DMA controller's hold-acknowledge input. A grant condition is formed from three things: the processor's active-low bus status lines, the active-low bus-lock line and the DMA hold request. That condition is captured in a first flip-flop. It then moves through further synchronising flip-flops before it reaches the acknowledge output.

A second path forces the grant condition true while the processor is writing to the DMA controller's own register window. Without it, a processor write to the controller could collide with a pending DMA request. The processor would then wait for the write to finish, while the controller waits for its acknowledge, and neither would move. The register window is decoded inside the block from the I/O address: it is the first 32 ports of the I/O space. Hold acknowledge is dropped on the first clock edge after the request goes away, so the bus comes back promptly.

Top module: `dma_hold_arb`

## Requirements
- R1: With `hold_req_i` high and no register write in progress, the grant condition is true only when `stat0_ni`, `stat1_ni` and `lock_ni` are all high.
- R2: The register window is selected when `io_cycle_i` is high and `io_addr_i[15:5]` is zero (ports 0x0000 to 0x001F). Addresses at 0x0020 and above, or any address with `io_cycle_i` low, do not select it.
- R3: A write to the window (window selected and `io_wr_ni` low) makes the grant condition true whatever the status and lock lines show.
- R4: With `hold_req_i` held high and the grant condition held true, `hold_ack_o` is still low after the second rising edge and high after the third.
- R5: `hold_ack_o` is low after any rising edge at which `hold_req_i` was sampled low.
- R6: If the grant condition goes false while `hold_req_i` stays high, `hold_ack_o` stays high after two more rising edges and is low after the third.
- R7: While `rst_ni` is low, `hold_ack_o` is low, without waiting for a clock edge.
- R8: `hold_ack_o` never rises unless `hold_req_i` was high at the edge where it rises, even during a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat0_ni | input | 1 | Processor status bit 0, active low |
| stat1_ni | input | 1 | Processor status bit 1, active low |
| lock_ni | input | 1 | Bus lock, active low (high = not locked) |
| hold_req_i | input | 1 | DMA hold request |
| io_cycle_i | input | 1 | I/O cycle in progress |
| io_addr_i | input | 16 | I/O port address |
| io_wr_ni | input | 1 | I/O write strobe, active low |
| hold_ack_o | output | 1 | Hold acknowledge to the DMA controller |

## Verification
Two functions can be active in the same cycle: the plain status/lock grant, and the forced grant from a register write. A write can also arrive while the status lines or the lock show the bus as busy. The bench sweeps every combination of status, lock, request, I/O cycle and write strobe, against addresses at both edges of the window and outside it. For each combination it computes the expected grant as an OR of the two terms. It judges `hold_ack_o` after the second and the third edge, and again after the request is withdrawn. Directed cases check two more things: a locked request waits until the lock is released, and a register write with an active status overrides the busy status.

// File: rtl/dma_hold_arb_pkg.sv
package dma_hold_arb_pkg;
  localparam int unsigned IO_ADDR_W  = 16;
  localparam int unsigned WIN_BITS   = 5;  // 32-port register window
  localparam int unsigned ACK_STAGES = 3;  // first grant flop + 2 sync flops

  typedef struct packed {
    logic base;   // status idle, unlocked, request present
    logic wr_win; // processor writing DMA register window
  } grant_terms_t;
endpackage

// File: rtl/dma_win_decode.sv
module dma_win_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BITS = 5
) (
  input  logic              io_cycle_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              sel_o
);
  localparam int unsigned UPPER_W = ADDR_W - WIN_BITS;

  logic [UPPER_W-1:0] upper;
  assign upper = io_addr_i[ADDR_W-1:WIN_BITS];
  assign sel_o = io_cycle_i && (upper == '0);
endmodule

// File: rtl/dma_grant_term.sv
module dma_grant_term
  import dma_hold_arb_pkg::*;
(
  input  logic         stat0_ni,
  input  logic         stat1_ni,
  input  logic         lock_ni,
  input  logic         hold_req_i,
  input  logic         win_sel_i,
  input  logic         io_wr_ni,
  output grant_terms_t terms_o,
  output logic         grant_o
);
  always_comb begin
    terms_o.base   = stat0_ni & stat1_ni & lock_ni & hold_req_i;
    terms_o.wr_win = ~(~win_sel_i | io_wr_ni);
    grant_o        = terms_o.base | terms_o.wr_win;
  end
endmodule

// File: rtl/dma_ack_chain.sv
module dma_ack_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic grant_i,
  output logic ack_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stg_q;

  // request withdrawal clears every stage at once
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic d;
    if (k == 0) begin : g_first
      assign d = grant_i;
    end else begin : g_next
      assign d = stg_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          stg_q[k] <= 1'b0;
      else if (!hold_req_i) stg_q[k] <= 1'b0;
      else                  stg_q[k] <= d;
    end

    if (k > 0) begin : g_chk
      // R4
      stage_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stg_q[k] |-> $past(stg_q[k-1]));
    end
  end

  assign ack_o = stg_q[LAST];

  // R1
  first_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && hold_req_i) |=> stg_q[0]);

  // R5
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_req_i |=> (stg_q == '0));
endmodule

// File: rtl/dma_hold_arb.sv
module dma_hold_arb
  import dma_hold_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned WBITS  = WIN_BITS,
  parameter int unsigned STAGES = ACK_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat0_ni,
  input  logic              stat1_ni,
  input  logic              lock_ni,
  input  logic              hold_req_i,
  input  logic              io_cycle_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_ni,
  output logic              hold_ack_o
);
  logic         win_sel;
  logic         grant;
  grant_terms_t terms;

  dma_win_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WBITS)) u_decode (
    .io_cycle_i(io_cycle_i),
    .io_addr_i (io_addr_i),
    .sel_o     (win_sel)
  );

  dma_grant_term u_term (
    .stat0_ni  (stat0_ni),
    .stat1_ni  (stat1_ni),
    .lock_ni   (lock_ni),
    .hold_req_i(hold_req_i),
    .win_sel_i (win_sel),
    .io_wr_ni  (io_wr_ni),
    .terms_o   (terms),
    .grant_o   (grant)
  );

  dma_ack_chain #(.STAGES(STAGES)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_req_i(hold_req_i),
    .grant_i   (grant),
    .ack_o     (hold_ack_o)
  );

  // R3
  win_write_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_cycle_i && io_addr_i[ADDR_W-1:WBITS] == '0 && !io_wr_ni) |-> grant);

  // R2
  win_outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_cycle_i || io_addr_i[ADDR_W-1:WBITS] != '0) |-> !terms.wr_win);

  // R8
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(hold_req_i));

  // R7
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !hold_ack_o);
endmodule

// File: tb/dma_hold_arb_tb.sv
module dma_hold_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        s0_n = 1'b1, s1_n = 1'b1, lock_n = 1'b1, req = 1'b0;
  logic        cyc = 1'b0, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic        ack;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dma_hold_arb dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .stat0_ni(s0_n), .stat1_ni(s1_n),
    .lock_ni(lock_n), .hold_req_i(req), .io_cycle_i(cyc),
    .io_addr_i(addr), .io_wr_ni(wr_n), .hold_ack_o(ack)
  );

  task automatic check(input string req_tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ack=%0b expected=%0b t=%0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic exp_grant(logic a0, logic a1, logic lk, logic rq,
                                     logic cy, logic wn, logic [15:0] ad);
    logic base, wr;
    base = a0 & a1 & lk & rq;
    wr   = cy & (ad < 16'd32) & ~wn;
    return rq & (base | wr);
  endfunction

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [15:0] addrs [4];
    addrs[0] = 16'h0000; addrs[1] = 16'h001F;
    addrs[2] = 16'h0020; addrs[3] = 16'hFFE0;

    #2 rst_ni = 1'b0;
    tick(2);
    check("R7 reset", ack, 1'b0);
    rst_ni = 1'b1;
    tick(1);
    check("R7 after reset", ack, 1'b0);

    // sweep: R1 R2 R3 R4 R5 R8
    for (int c = 0; c < 64; c++) begin
      for (int a = 0; a < 4; a++) begin
        logic e;
        req = 1'b0; s0_n = 1'b1; s1_n = 1'b1; lock_n = 1'b1; cyc = 1'b0; wr_n = 1'b1;
        tick(1);
        s0_n = c[0]; s1_n = c[1]; lock_n = c[2]; req = c[3]; cyc = c[4]; wr_n = c[5];
        addr = addrs[a];
        e = exp_grant(c[0], c[1], c[2], c[3], c[4], c[5], addrs[a]);
        tick(2);
        check("R4 two edges", ack, 1'b0);
        tick(1);
        if (!c[3]) check("R8 no req", ack, 1'b0);
        else if (c[4] && !c[5]) check("R3/R2 window write", ack, e);
        else check("R1 base term", ack, e);
        if (e) begin
          req = 1'b0;
          tick(1);
          check("R5 release", ack, 1'b0);
        end
      end
    end

    // locked request waits for unlock (R1)
    req = 1'b0; cyc = 1'b0; wr_n = 1'b1; s0_n = 1'b1; s1_n = 1'b1; lock_n = 1'b0;
    tick(1);
    req = 1'b1;
    tick(10);
    check("R1 locked", ack, 1'b0);
    lock_n = 1'b1;
    tick(2);
    check("R4 unlock +2", ack, 1'b0);
    tick(1);
    check("R4 unlock +3", ack, 1'b1);

    // grant lost with request held (R6)
    lock_n = 1'b0;
    tick(2);
    check("R6 lost +2", ack, 1'b1);
    tick(1);
    check("R6 lost +3", ack, 1'b0);

    // register write overrides active status and lock (R3)
    s0_n = 1'b0; s1_n = 1'b0; cyc = 1'b1; addr = 16'h000A; wr_n = 1'b0;
    tick(3);
    check("R3 write override", ack, 1'b1);

    // asynchronous reset mid-grant (R7)
    #2 rst_ni = 1'b0;
    #1 check("R7 async", ack, 1'b0);
    tick(1);
    rst_ni = 1'b1;
    req = 1'b0;
    tick(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule